// File: doc/BRIEF.md
# Stop-Clock Grant Controller

This controller sits between the system's power-management logic and the clock-enable network of a processor. The power-management logic drives an asynchronous, active-low stop-clock request. The controller synchronizes that request to the bus clock and sends a one-cycle stop-grant acknowledge pulse towards the bus interface. It then waits until the core reports that it is idle, and only then drops the clock enables of the core domains. The bus-interface and interrupt-controller enables are never dropped, so snooping and interrupt service go on while the core sleeps.

When the request is released, every core enable comes back and a one-cycle resume pulse tells the core that it may continue. A request that goes away while the controller is still waiting for the core to go idle finishes its acknowledge and then goes straight to the wake-up step. In that case the core enables never drop. All enables are updated only on the falling edge of the bus clock, so the gating cells downstream see a stable enable across each rising edge. The bus clock itself is never touched by this block.

Top module: `stopclk_grant_ctrl`

## Requirements
- R1: The request `stop_req_n` passes through `SYNC_STAGES` flip-flops before the controller acts on it. If the request goes low just after a rising edge, `grant_ack` is high when sampled after the (SYNC_STAGES+1)-th following rising edge.
- R2: Each entry into the stop sequence produces exactly one `grant_ack` pulse, one bus-clock cycle wide. The pulse is never followed by a second high cycle.
- R3: The core enables `core_clk_en` (all bits) drop only after the acknowledge pulse has ended, and only while `core_idle` is high. Every bit stays low for as long as the low-power grant state lasts.
- R4: After reset, `bus_clk_en` and `intc_clk_en` stay high at all times, including the low-power grant state.
- R5: Releasing the request during the grant state restores every core enable and produces a single one-cycle `resume_pulse`. The controller is back in run on the following cycle.
- R6: If the synchronized request drops while the controller waits for `core_idle` after its acknowledge, the controller goes directly to wake-up (with one `resume_pulse`) and no core enable ever drops.
- R7: Every clock enable changes only on the falling edge of `clk`. It never changes at a rising edge.
- R8: While the request is held and `core_idle` is low, the controller keeps waiting: all core enables stay high and no further acknowledge is issued.
- R9: In reset and in run with the request high, `grant_ack` and `resume_pulse` are low and all enables are high, whatever `core_idle` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop-clock request |
| core_idle | input | 1 | High when the core has reached an idle point |
| grant_ack | output | 1 | One-cycle stop-grant acknowledge pulse to the bus interface |
| core_clk_en | output | NUM_CORE_DOMAINS | Clock enables of the core domains |
| bus_clk_en | output | 1 | Clock enable of the bus-interface domain |
| intc_clk_en | output | 1 | Clock enable of the interrupt-controller domain |
| resume_pulse | output | 1 | One-cycle indication that execution may resume |

## Verification
The bench builds the controller with a three-stage synchronizer and four core domains, rather than the defaults of two and two. The longer synchronizer makes the acknowledge latency differ visibly from a two-flop version, and it leaves room to drop the request inside the wait-for-idle window. Four core domains show that every lane of the gated vector goes low and comes back together, and not just the first lane.

// File: rtl/scg_pkg.sv
package scg_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ACK   = 2'd1,
    ST_GRANT = 2'd2,
    ST_WAKE  = 2'd3
  } scg_state_e;

  // Core domains run in every state except the granted low-power one.
  function automatic logic core_enable_for(scg_state_e s);
    return (s != ST_GRANT);
  endfunction

  // An enable lane is on if it belongs to an always-on domain or the core may run.
  function automatic logic lane_enable(logic always_on, logic core_want);
    return always_on | core_want;
  endfunction

  // The acknowledge fires on the step out of run.
  function automatic logic ack_due(scg_state_e s, logic req);
    return (s == ST_RUN) && req;
  endfunction

  function automatic scg_state_e next_state(scg_state_e s, logic req,
                                            logic idle, logic ack_busy);
    scg_state_e n;
    n = s;
    unique case (s)
      ST_RUN:   if (req) n = ST_ACK;
      ST_ACK: begin
        if (ack_busy)  n = ST_ACK;
        else if (!req) n = ST_WAKE;
        else if (idle) n = ST_GRANT;
      end
      ST_GRANT: if (!req) n = ST_WAKE;
      ST_WAKE:  n = ST_RUN;
      default:  n = ST_RUN;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/scg_sync.sv
module scg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_req_n,
  output logic req_active
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= ~async_req_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], ~async_req_n};
      end
    end
  endgenerate

  assign req_active = chain_q[LAST];
endmodule

// File: rtl/scg_fsm.sv
module scg_fsm
  import scg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_active,
  input  logic       core_idle,
  output scg_state_e state,
  output logic       ack_pulse,
  output logic       resume_pulse,
  output logic       core_want
);
  scg_state_e state_q, state_d;
  logic       ack_q;

  assign state_d = next_state(state_q, req_active, core_idle, ack_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_due(state_q, req_active);
    end
  end

  assign state        = state_q;
  assign ack_pulse    = ack_q;
  assign resume_pulse = (state_q == ST_WAKE);
  assign core_want    = core_enable_for(state_q);
endmodule

// File: rtl/scg_en_gate.sv
module scg_en_gate
  import scg_pkg::*;
#(
  parameter int NUM_CORE   = 2,
  parameter int NUM_ALWAYS = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           core_want,
  output logic [NUM_CORE+NUM_ALWAYS-1:0] lane_en
);
  localparam int LANES = NUM_CORE + NUM_ALWAYS;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic ALWAYS_ON = (g >= NUM_CORE);
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) lane_en[g] <= 1'b1;
        else        lane_en[g] <= lane_enable(ALWAYS_ON, core_want);
      end
    end
  endgenerate
endmodule

// File: rtl/stopclk_grant_ctrl.sv
module stopclk_grant_ctrl
  import scg_pkg::*;
#(
  parameter int SYNC_STAGES      = 2,
  parameter int NUM_CORE_DOMAINS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        stop_req_n,
  input  logic                        core_idle,
  output logic                        grant_ack,
  output logic [NUM_CORE_DOMAINS-1:0] core_clk_en,
  output logic                        bus_clk_en,
  output logic                        intc_clk_en,
  output logic                        resume_pulse
);
  localparam int NUM_ALWAYS = 2;
  localparam int LANES      = NUM_CORE_DOMAINS + NUM_ALWAYS;

  // Named internal events, visible to the bound checker.
  logic             req_sync;
  scg_state_e       fsm_state;
  logic             in_grant;
  logic             core_want;
  logic [LANES-1:0] lane_en;

  scg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_req_n(stop_req_n),
    .req_active (req_sync)
  );

  scg_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_active  (req_sync),
    .core_idle   (core_idle),
    .state       (fsm_state),
    .ack_pulse   (grant_ack),
    .resume_pulse(resume_pulse),
    .core_want   (core_want)
  );

  scg_en_gate #(.NUM_CORE(NUM_CORE_DOMAINS), .NUM_ALWAYS(NUM_ALWAYS)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_want(core_want),
    .lane_en  (lane_en)
  );

  assign in_grant    = (fsm_state == ST_GRANT);
  assign core_clk_en = lane_en[NUM_CORE_DOMAINS-1:0];
  assign bus_clk_en  = lane_en[NUM_CORE_DOMAINS];
  assign intc_clk_en = lane_en[NUM_CORE_DOMAINS+1];
endmodule

// File: rtl/scg_chk.sv
module scg_chk
  import scg_pkg::*;
#(
  parameter int N = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         core_idle,
  input logic         grant_ack,
  input logic         resume_pulse,
  input logic [N-1:0] core_clk_en,
  input logic         bus_clk_en,
  input logic         intc_clk_en,
  input logic         req_sync,
  input logic         in_grant,
  input scg_state_e   fsm_state
);
  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_ack |=> !grant_ack);

  // R2
  ack_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_ack |-> (fsm_state == ST_ACK));

  // R3
  gate_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_grant) |-> ($past(fsm_state) == ST_ACK) && $past(core_idle) && !$past(grant_ack));

  // R3
  core_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(core_clk_en) == (in_grant ? 0 : N));

  // R4
  always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk_en && intc_clk_en);

  // R5
  release_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_grant && !req_sync) |=> (fsm_state == ST_WAKE) && resume_pulse);

  // R5
  resume_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> (fsm_state == ST_RUN) && !resume_pulse);

  // R6
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fsm_state == ST_ACK) && !grant_ack && !req_sync) |=> (fsm_state == ST_WAKE));

  // R7
  always @(core_clk_en or bus_clk_en or intc_clk_en) begin
    if (rst_n) begin
      edge_chk: assert (!clk);
    end
  end
endmodule

bind stopclk_grant_ctrl scg_chk #(.N(NUM_CORE_DOMAINS)) u_scg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_idle   (core_idle),
  .grant_ack   (grant_ack),
  .resume_pulse(resume_pulse),
  .core_clk_en (core_clk_en),
  .bus_clk_en  (bus_clk_en),
  .intc_clk_en (intc_clk_en),
  .req_sync    (req_sync),
  .in_grant    (in_grant),
  .fsm_state   (fsm_state)
);

// File: tb/test_stopclk_grant_ctrl.sv
module test_stopclk_grant_ctrl;
  localparam int S = 3;
  localparam int N = 4;
  localparam int M_RUN = 0, M_ACK = 1, M_GRANT = 2, M_WAKE = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic stop_req_n;
  logic core_idle;
  logic grant_ack;
  logic [N-1:0] core_clk_en;
  logic bus_clk_en;
  logic intc_clk_en;
  logic resume_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  stopclk_grant_ctrl #(.SYNC_STAGES(S), .NUM_CORE_DOMAINS(N)) i_stopclk_grant_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .core_idle(core_idle),
    .grant_ack(grant_ack), .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
    .intc_clk_en(intc_clk_en), .resume_pulse(resume_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard: reference model pushes expected outputs, monitor pops them.
  typedef struct packed { logic ack; logic res; logic core; } exp_t;
  exp_t q[$];
  int m_st = M_RUN;
  logic m_ack = 1'b0;
  logic [S-1:0] m_sync = '0;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      m_st = M_RUN; m_ack = 1'b0; m_sync = '0; q.delete();
    end else begin
      logic rq;
      int nst;
      exp_t e;
      rq = m_sync[S-1];
      nst = m_st;
      case (m_st)
        M_RUN:   if (rq) nst = M_ACK;
        M_ACK:   if (!m_ack) begin
                   if (!rq) nst = M_WAKE;
                   else if (core_idle) nst = M_GRANT;
                 end
        M_GRANT: if (!rq) nst = M_WAKE;
        default: nst = M_RUN;
      endcase
      m_ack = (m_st == M_RUN) && rq;
      m_sync = {m_sync[S-2:0], ~stop_req_n};
      m_st = nst;
      e.ack = m_ack; e.res = (m_st == M_WAKE); e.core = (m_st != M_GRANT);
      q.push_back(e);
    end
  end

  int ack_cnt = 0, res_cnt = 0;
  bit core_low = 0;

  always @(posedge clk) begin
    #14;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(grant_ack == e.ack, "R2 ack", grant_ack, e.ack);
      check(resume_pulse == e.res, "R5 resume", resume_pulse, e.res);
      check(core_clk_en == {N{e.core}}, "R3 core_en", core_clk_en, {N{e.core}});
      check(bus_clk_en && intc_clk_en, "R4 always-on", {bus_clk_en, intc_clk_en}, 3);
      if (grant_ack) ack_cnt++;
      if (resume_pulse) res_cnt++;
      if (core_clk_en != '1) core_low = 1;
    end
  end

  // R7: enables must hold across every rising edge.
  logic [N+1:0] neg_snap;
  always @(negedge clk) begin #3; neg_snap = {intc_clk_en, bus_clk_en, core_clk_en}; end
  always @(posedge clk) begin
    #3;
    if (rst_n)
      check({intc_clk_en, bus_clk_en, core_clk_en} == neg_snap, "R7 edge",
            {intc_clk_en, bus_clk_en, core_clk_en}, neg_snap);
  end

  task automatic smp(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #14; end
  endtask

  initial begin
    rst_n = 1'b0; stop_req_n = 1'b1; core_idle = 1'b0;
    #45;
    // R9 reset state
    check(!grant_ack && !resume_pulse, "R9 reset pulses", {grant_ack, resume_pulse}, 0);
    check(core_clk_en == '1 && bus_clk_en && intc_clk_en, "R9 reset enables",
          {intc_clk_en, bus_clk_en, core_clk_en}, {(N+2){1'b1}});
    #10 rst_n = 1'b1;
    smp(1);
    // R9: run with idle toggling, request inactive
    for (int k = 0; k < 6; k++) begin core_idle = k[0]; smp(1); end
    check(ack_cnt == 0 && !core_low, "R9 no action", ack_cnt, 0);

    // R1 latency, R2 single pulse, R8 wait, R3 gating, R5 release
    core_idle = 1'b0; stop_req_n = 1'b0;
    smp(S);
    check(grant_ack == 1'b0, "R1 not early", grant_ack, 0);
    smp(1);
    check(grant_ack == 1'b1, "R1 ack latency", grant_ack, 1);
    smp(1);
    check(grant_ack == 1'b0, "R2 pulse width", grant_ack, 0);
    smp(5);
    check(core_clk_en == '1 && ack_cnt == 1, "R8 waiting for idle", ack_cnt, 1);
    core_idle = 1'b1;
    smp(3);
    check(core_clk_en == '0, "R3 gated", core_clk_en, 0);
    check(bus_clk_en && intc_clk_en, "R4 in grant", {bus_clk_en, intc_clk_en}, 3);
    smp(4);
    stop_req_n = 1'b1;
    smp(S + 1);
    check(resume_pulse && core_clk_en == '1, "R5 wake", {resume_pulse, core_clk_en}, {1'b1, {N{1'b1}}});
    smp(1);
    check(!resume_pulse && res_cnt == 1, "R5 single resume", res_cnt, 1);
    smp(4);

    // R6: request dropped during the wait for idle
    core_idle = 1'b0; core_low = 0;
    stop_req_n = 1'b0;
    smp(S + 1);
    stop_req_n = 1'b1;
    smp(2 * S + 4);
    check(!core_low, "R6 no gating", core_low, 0);
    check(ack_cnt == 2 && res_cnt == 2, "R6 ack and resume", {ack_cnt, res_cnt}, {32'd2, 32'd2});

    // Short request glitch plus fast grant with core already idle
    stop_req_n = 1'b0; smp(1); stop_req_n = 1'b1; smp(2 * S + 4);
    core_idle = 1'b1; stop_req_n = 1'b0; smp(S + 6);
    check(core_clk_en == '0, "R3 fast grant", core_clk_en, 0);
    stop_req_n = 1'b1; smp(S + 4);
    check(ack_cnt == 4 && res_cnt == 4, "R2 R5 entry counts", {ack_cnt, res_cnt}, {32'd4, 32'd4});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule